// File: doc/BRIEF.md
# Descriptor-Table DMA Controller

This block moves data between a disk-style device and system memory without processor involvement per word. Software places a table of region descriptors in memory, loads the table's address, chooses a direction and sets a start bit. The controller then reads each descriptor into internal address and count registers, moves one 32-bit word per memory transaction until the region's byte count is used up, and goes on to the next descriptor. It stops on its own after the descriptor that carries the end-of-table flag.

Each descriptor is two words. The first word is the region's byte address. The second word holds a 16-bit byte count in bits [15:0], where 0 stands for 64 KB, and the end-of-table flag in bit 31. Memory traffic goes through a single request/grant port. A transaction completes in the cycle in which both request and grant are high. Read data and the error flag are valid in that same cycle. The device side has a request input, an acknowledge output and a one-cycle beat strobe.

The register port has three registers. Index 0 is the command register: bit 0 is start and bit 1 is direction, where 1 means device to memory (memory writes). Index 1 is the status register: bit 0 is active and read-only, bit 1 is error and bit 2 is interrupt, and both of those are cleared by writing 1. Index 2 is the table pointer. The current address and count registers cannot be read.

Top module: `dtdma_ctrl`

## Requirements
- R1: While reset is low and right after it, all three registers read 0, `mem_req` is 0 and `dev_dack` is 0.
- R2: The table pointer always reads back with bits [1:0] equal to 0, whatever value was written.
- R3: A write that takes the start bit from 0 to 1 sets active. The first two memory reads are then issued at the table pointer and at the table pointer plus 4.
- R4: `dev_dack` stays low while a descriptor is being fetched. It rises only in the cycle after the descriptor's count word has been read.
- R5: With direction 1, each data beat is a memory write of `dev_wdata`. With direction 0, each data beat is a memory read, and the word read appears on `dev_rdata` with `dev_beat` high.
- R6: Data beats start at the descriptor address with bit 0 forced to 0, and step by 4. The count drops by 4 per beat, or by the remainder if fewer than 4 bytes are left. A count field of 0 moves 65536 bytes.
- R7: When a descriptor without end-of-table is used up, the next one is fetched 8 bytes further on. The addition wraps within address bits [15:0], so the upper bits stay the same.
- R8: When the end-of-table descriptor is used up, active clears, `dev_dack` falls and no further memory request is made.
- R9: Writing 0 to the start bit ends the transfer. No memory request is made from the next cycle on, and active clears.
- R10: A memory error on a granted transaction sets the error bit and stops the transfer. Writing 1 to bit 1 clears the error bit and writing 0 leaves it set.
- R11: A high `dev_irq` sets the interrupt bit. Writing 1 to bit 2 clears it and writing 0 leaves it set.
- R12: During a data phase, no memory request is made while `dev_dreq` is low, and `dev_dack` stays high while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | 2 | Register index |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| mem_gnt | input | 1 | Grant; completes the transaction this cycle |
| mem_err | input | 1 | Error flag, valid with grant |
| dev_dreq | input | 1 | Device ready to move a word |
| dev_dack | output | 1 | Acknowledge to the device during data phases |
| dev_wdata | input | 32 | Word from the device (device to memory) |
| dev_rdata | output | 32 | Word to the device (memory to device) |
| dev_beat | output | 1 | One data word moved this cycle |
| dev_irq | input | 1 | Device interrupt line |

## Verification
The assertions check on every cycle the properties that never depend on the table's contents. Acknowledge rises only straight after a descriptor read. Nothing is requested while the controller is idle, while start is clear, or while the device is not ready in a data phase. An errored grant leaves the error bit set and the controller idle. The pointer reads back aligned. The bench scenarios cover what depends on the values involved: the exact address sequence through a table, the wrap at the 64 KB window, the partial final beat, the 64 KB count, the data passed in each direction, and the write-1-to-clear behaviour of the two status bits.

// File: rtl/dtdma_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the descriptor-table DMA controller.
// Assumes 32-bit register and memory data words.
package dtdma_pkg;
    localparam int DWORD_BITS   = 32;
    localparam int BEAT_BYTES   = DWORD_BITS / 8;
    localparam int DESC_STRIDE  = 8;
    localparam int DESC_CNT_OFS = 4;
    localparam int DESC_EOT_BIT = 31;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_TPTR = 2'd2;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 1;
    localparam int ST_ACTIVE_BIT = 0;
    localparam int ST_ERR_BIT    = 1;
    localparam int ST_IRQ_BIT    = 2;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FETCH_BASE,
        SQ_FETCH_CNT,
        SQ_MOVE
    } seq_state_e;
endpackage

// File: rtl/dtdma_regfile.sv
`timescale 1ns/1ps
// Software-visible command, status and table-pointer registers.
// Assumes ADDR_W <= 32. Status set events take priority over a
// simultaneous write-1-to-clear.
module dtdma_regfile
    import dtdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [1:0]        sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic              busy,
    input  logic              err_set,
    input  logic              dev_irq,
    output logic              cmd_start,
    output logic              cmd_dir,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] tbl_ptr,
    output logic              err_flag,
    output logic              irq_flag
);
    logic wr_cmd, wr_stat, wr_tptr;
    logic [31:0] tp_wide;

    // Decode register write strobes.
    always_comb begin
        wr_cmd  = sw_wr && (sw_addr == REG_CMD);
        wr_stat = sw_wr && (sw_addr == REG_STAT);
        wr_tptr = sw_wr && (sw_addr == REG_TPTR);
    end

    // A transfer is launched only by a 0-to-1 write of the start bit.
    assign start_pulse = wr_cmd && sw_wdata[CMD_START_BIT] && !cmd_start;

    // Command register and word-aligned table pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start <= 1'b0;
            cmd_dir   <= 1'b0;
            tbl_ptr   <= '0;
        end else begin
            if (wr_cmd) begin
                cmd_start <= sw_wdata[CMD_START_BIT];
                cmd_dir   <= sw_wdata[CMD_DIR_BIT];
            end
            if (wr_tptr) begin
                tbl_ptr <= {sw_wdata[ADDR_W-1:2], 2'b00};
            end
        end
    end

    // Sticky status bits with write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (err_set)
                err_flag <= 1'b1;
            else if (wr_stat && sw_wdata[ST_ERR_BIT])
                err_flag <= 1'b0;
            if (dev_irq)
                irq_flag <= 1'b1;
            else if (wr_stat && sw_wdata[ST_IRQ_BIT])
                irq_flag <= 1'b0;
        end
    end

    // Read-back multiplexer; hidden cursor registers are not mapped.
    always_comb begin
        tp_wide = '0;
        tp_wide[ADDR_W-1:0] = tbl_ptr;
        sw_rdata = '0;
        case (sw_addr)
            REG_CMD: begin
                sw_rdata[CMD_START_BIT] = cmd_start;
                sw_rdata[CMD_DIR_BIT]   = cmd_dir;
            end
            REG_STAT: begin
                sw_rdata[ST_ACTIVE_BIT] = busy;
                sw_rdata[ST_ERR_BIT]    = err_flag;
                sw_rdata[ST_IRQ_BIT]    = irq_flag;
            end
            REG_TPTR: sw_rdata = tp_wide;
            default:  sw_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dtdma_cursor.sv
`timescale 1ns/1ps
// Hidden current-address and current-count registers for the region
// being moved. The count is one bit wider than the descriptor field so
// that a zero field can stand for the full 2**CNT_W bytes.
module dtdma_cursor
    import dtdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              load_cnt,
    input  logic              advance,
    input  logic [ADDR_W-1:1] base_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              eot_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_eot,
    output logic              last_beat
);
    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] BEAT_CW = CW'(BEAT_BYTES);
    localparam logic [CW-1:0] FULL_CW = {1'b1, {CNT_W{1'b0}}};

    logic [CW-1:0] cur_cnt;
    logic [CW-1:0] step;

    // Bytes moved by the next beat: a full word or the remainder.
    always_comb begin
        step      = (cur_cnt < BEAT_CW) ? cur_cnt : BEAT_CW;
        last_beat = (cur_cnt <= BEAT_CW);
    end

    // Load from descriptor words, then step per completed beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            cur_eot  <= 1'b0;
        end else begin
            if (load_base) begin
                cur_addr <= {base_in, 1'b0};
            end
            if (load_cnt) begin
                cur_cnt <= (cnt_in == '0) ? FULL_CW : {1'b0, cnt_in};
                cur_eot <= eot_in;
            end
            if (advance) begin
                cur_addr <= cur_addr + ADDR_W'(BEAT_BYTES);
                cur_cnt  <= cur_cnt - step;
            end
        end
    end
endmodule

// File: rtl/dtdma_seq.sv
`timescale 1ns/1ps
// Descriptor sequencer: fetches the two words of each descriptor, runs
// the data phase, and walks the table until the end-of-table entry is
// used up. Clearing start or a memory error returns it to idle. A memory
// transaction completes in the cycle where request and grant are both high.
module dtdma_seq
    import dtdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_dir,
    input  logic              start_pulse,
    input  logic [ADDR_W-1:0] tbl_ptr,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_eot,
    input  logic              last_beat,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic              dev_dreq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              dev_dack,
    output logic              busy,
    output logic              load_base,
    output logic              load_cnt,
    output logic              advance,
    output logic              err_set
);
    seq_state_e        state;
    logic [ADDR_W-1:0] desc_ptr;
    logic              done;

    // Add an offset inside the low WIN_W bits; upper bits are kept.
    function automatic logic [ADDR_W-1:0] win_add(input logic [ADDR_W-1:0] p,
                                                  input int ofs);
        logic [ADDR_W-1:0] r;
        r = p;
        r[WIN_W-1:0] = p[WIN_W-1:0] + WIN_W'(ofs);
        return r;
    endfunction

    // Memory request, address and per-cycle event decode.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = desc_ptr;
        case (state)
            SQ_FETCH_BASE: mem_req = cmd_start;
            SQ_FETCH_CNT: begin
                mem_req  = cmd_start;
                mem_addr = win_add(desc_ptr, DESC_CNT_OFS);
            end
            SQ_MOVE: begin
                mem_req  = cmd_start && dev_dreq;
                mem_we   = cmd_dir;
                mem_addr = cur_addr;
            end
            default: ;
        endcase
        done      = mem_req && mem_gnt;
        err_set   = done && mem_err;
        load_base = done && !mem_err && (state == SQ_FETCH_BASE);
        load_cnt  = done && !mem_err && (state == SQ_FETCH_CNT);
        advance   = done && !mem_err && (state == SQ_MOVE);
        dev_dack  = (state == SQ_MOVE);
        busy      = (state != SQ_IDLE);
    end

    // State progression and descriptor pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            desc_ptr <= '0;
        end else if (state == SQ_IDLE) begin
            if (start_pulse) begin
                desc_ptr <= tbl_ptr;
                state    <= SQ_FETCH_BASE;
            end
        end else if (!cmd_start || err_set) begin
            state <= SQ_IDLE;
        end else if (load_base) begin
            state <= SQ_FETCH_CNT;
        end else if (load_cnt) begin
            state <= SQ_MOVE;
        end else if (advance && last_beat) begin
            if (cur_eot) begin
                state <= SQ_IDLE;
            end else begin
                desc_ptr <= win_add(desc_ptr, DESC_STRIDE);
                state    <= SQ_FETCH_BASE;
            end
        end
    end
endmodule

// File: rtl/dtdma_ctrl.sv
`timescale 1ns/1ps
// Top of the descriptor-table DMA controller: register file, descriptor
// sequencer and hidden cursor. Assumes a single-cycle request/grant
// memory port whose read data and error are valid with the grant.
module dtdma_ctrl
    import dtdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [1:0]        sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic              dev_dreq,
    output logic              dev_dack,
    input  logic [31:0]       dev_wdata,
    output logic [31:0]       dev_rdata,
    output logic              dev_beat,
    input  logic              dev_irq
);
    logic              cmd_start, cmd_dir, start_pulse;
    logic [ADDR_W-1:0] tbl_ptr;
    logic              err_flag, irq_flag, busy;
    logic              load_base, load_cnt, advance, err_set;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_eot, last_beat;

    dtdma_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .busy(busy), .err_set(err_set), .dev_irq(dev_irq),
        .cmd_start(cmd_start), .cmd_dir(cmd_dir), .start_pulse(start_pulse),
        .tbl_ptr(tbl_ptr), .err_flag(err_flag), .irq_flag(irq_flag)
    );

    dtdma_seq #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_dir(cmd_dir), .start_pulse(start_pulse),
        .tbl_ptr(tbl_ptr), .cur_addr(cur_addr), .cur_eot(cur_eot), .last_beat(last_beat),
        .mem_gnt(mem_gnt), .mem_err(mem_err), .dev_dreq(dev_dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .dev_dack(dev_dack), .busy(busy),
        .load_base(load_base), .load_cnt(load_cnt), .advance(advance), .err_set(err_set)
    );

    dtdma_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
        .clk(clk), .rst_n(rst_n),
        .load_base(load_base), .load_cnt(load_cnt), .advance(advance),
        .base_in(mem_rdata[ADDR_W-1:1]), .cnt_in(mem_rdata[CNT_W-1:0]),
        .eot_in(mem_rdata[DESC_EOT_BIT]),
        .cur_addr(cur_addr), .cur_eot(cur_eot), .last_beat(last_beat)
    );

    // Data paths between device and memory port.
    assign mem_wdata = mem_we ? dev_wdata : '0;
    assign dev_rdata = mem_rdata;
    assign dev_beat  = advance;
endmodule

// File: rtl/dtdma_ctrl_checker.sv
`timescale 1ns/1ps
// Protocol checker for dtdma_ctrl, attached with bind.
module dtdma_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_gnt,
    input logic        mem_err,
    input logic        dev_dreq,
    input logic        dev_dack,
    input logic        busy,
    input logic        cmd_start,
    input logic        err_flag,
    input logic [1:0]  sw_addr,
    input logic [31:0] sw_rdata
);
    // R4: acknowledge rises only right after a successful descriptor read.
    a_r4_dack_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_dack) |-> $past(mem_req && mem_gnt && !mem_we && !mem_err));

    // R4: no acknowledge while idle.
    a_r4_no_dack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dev_dack);

    // R8: an idle controller makes no memory request.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: no request while the start bit is clear.
    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_start |-> !mem_req);

    // R10: an errored grant leaves the error bit set and the sequencer idle.
    a_r10_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> (err_flag && !busy));

    // R12: data-phase requests only while the device is ready.
    a_r12_req_needs_dreq: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_dack && mem_req) |-> dev_dreq);

    // R2: table pointer reads back aligned.
    a_r2_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_addr == 2'd2) |-> (sw_rdata[1:0] == 2'b00));
endmodule

bind dtdma_ctrl dtdma_ctrl_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .dev_dreq(dev_dreq), .dev_dack(dev_dack),
    .busy(busy), .cmd_start(cmd_start), .err_flag(err_flag),
    .sw_addr(sw_addr), .sw_rdata(sw_rdata)
);

// File: tb/dtdma_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the table loader pushes expected memory transactions,
// the memory model pops and compares them as grants are given.
module dtdma_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_gnt = 1'b0;
    logic        mem_err = 1'b0;
    logic        dev_dreq = 1'b1;
    logic        dev_dack;
    logic [31:0] dev_wdata = 32'hD000_0001;
    logic [31:0] dev_rdata;
    logic        dev_beat;
    logic        dev_irq = 1'b0;

    always #2.5 clk = ~clk;

    dtdma_ctrl u_dtdma_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
        .dev_dreq(dev_dreq), .dev_dack(dev_dack), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_beat(dev_beat), .dev_irq(dev_irq)
    );

    typedef struct {
        bit          desc;
        bit          we;
        logic [31:0] addr;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] mem_img [logic [31:0]];
    int          n_checks = 0;
    int          n_errs = 0;
    int          grants = 0;
    bit          stall_en = 1'b1;
    bit          err_en = 1'b0;
    logic [31:0] err_addr = '0;
    bit          dreq_watch = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] win_add(input logic [31:0] p, input int ofs);
        return {p[31:16], p[15:0] + 16'(ofs)};
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    // Memory model and monitor: grant, answer, compare against the queue.
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_gnt   = mem_req && !(stall_en && (cyc % 3 == 0));
            mem_rdata = rd_word(mem_addr);
            mem_err   = mem_gnt && err_en && (mem_addr == err_addr);
            #1;
            if (dreq_watch && dev_dack && !dev_dreq)
                check(!mem_req, "R12", 32'(mem_req), 32'd0);
            if (mem_gnt) begin
                grants++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 unexpected request", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(mem_addr == e.addr, e.req, mem_addr, e.addr);
                    check(mem_we == e.we, "R5", 32'(mem_we), 32'(e.we));
                    if (e.desc)
                        check(!dev_dack, "R4", 32'(dev_dack), 32'd0);
                    else if (!mem_err) begin
                        check(dev_beat, "R5", 32'(dev_beat), 32'd1);
                        if (e.we) begin
                            check(mem_wdata == dev_wdata, "R5", mem_wdata, dev_wdata);
                            dev_wdata = dev_wdata + 32'h0000_0011;
                        end else begin
                            check(dev_rdata == rd_word(e.addr), "R5", dev_rdata, rd_word(e.addr));
                        end
                    end
                end
            end
        end
    end

    task automatic sw_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
        @(posedge clk); #1;
        sw_wr = 1'b0;
    endtask

    task automatic sw_read(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        sw_addr = a;
        #1;
        d = sw_rdata;
    endtask

    // Driver: build a table in the memory image and queue the expected traffic.
    task automatic load_table(input logic [31:0] ptr, input logic [31:0] bases[],
                              input int cnts[], input bit dir);
        logic [31:0] p = ptr;
        for (int i = 0; i < bases.size(); i++) begin
            logic [31:0] a;
            int bytes;
            bit last = (i == bases.size() - 1);
            mem_img[p] = bases[i];
            mem_img[win_add(p, 4)] = {last, 15'd0, cnts[i][15:0]};
            sb_q.push_back('{1'b1, 1'b0, p, (i == 0) ? "R3" : "R7"});
            sb_q.push_back('{1'b1, 1'b0, win_add(p, 4), (i == 0) ? "R3" : "R7"});
            bytes = (cnts[i][15:0] == 0) ? 65536 : cnts[i][15:0];
            a = {bases[i][31:1], 1'b0};
            while (bytes > 0) begin
                sb_q.push_back('{1'b0, dir, a, "R6"});
                a = a + 4;
                bytes = bytes - ((bytes < 4) ? bytes : 4);
            end
            p = win_add(p, 8);
        end
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 40000; i++) begin
            sw_read(2'd1, st);
            if (!st[0]) break;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int g0;
        // R1: reset state
        repeat (3) @(posedge clk);
        sw_read(2'd0, rd); check(rd == 0, "R1", rd, 0);
        sw_read(2'd1, rd); check(rd == 0, "R1", rd, 0);
        sw_read(2'd2, rd); check(rd == 0, "R1", rd, 0);
        check(!mem_req && !dev_dack, "R1", {mem_req, dev_dack}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        sw_read(2'd1, rd); check(rd == 0, "R1", rd, 0);

        // R2: alignment of the table pointer
        sw_write(2'd2, 32'h0000_1003);
        sw_read(2'd2, rd); check(rd == 32'h0000_1000, "R2", rd, 32'h0000_1000);

        // Scenario A: device to memory, two descriptors, device pauses (R3 R5 R6 R12 R8)
        load_table(32'h0000_1000, '{32'h0000_2000, 32'h0000_3001}, '{40, 6}, 1'b1);
        sw_write(2'd0, 32'h3);
        sw_read(2'd1, rd); check(rd[0] == 1'b1, "R3", rd, 1);
        repeat (6) @(posedge clk);
        #1 dev_dreq = 1'b0; dreq_watch = 1'b1;
        repeat (2) @(posedge clk);
        #1 check(dev_dack, "R12", 32'(dev_dack), 1);
        repeat (4) @(posedge clk);
        #1 dev_dreq = 1'b1; dreq_watch = 1'b0;
        wait_idle();
        sw_read(2'd1, rd); check(rd[0] == 1'b0, "R8", rd, 0);
        check(sb_q.size() == 0, "R8", sb_q.size(), 0);
        repeat (5) @(posedge clk);
        #1 check(!dev_dack && !mem_req, "R8", {dev_dack, mem_req}, 0);

        // Scenario B: memory to device, table wraps in its 64 KB window (R7 R5)
        sw_write(2'd0, 32'h0);
        sw_write(2'd2, 32'h0001_FFF8);
        load_table(32'h0001_FFF8, '{32'h0000_5000, 32'h0000_6000}, '{8, 4}, 1'b0);
        sw_write(2'd0, 32'h1);
        wait_idle();
        check(sb_q.size() == 0, "R7", sb_q.size(), 0);

        // Scenario C: a zero count moves 64 KB (R6)
        stall_en = 1'b0;
        sw_write(2'd0, 32'h0);
        sw_write(2'd2, 32'h0000_8000);
        load_table(32'h0000_8000, '{32'h0010_0000}, '{0}, 1'b1);
        g0 = grants;
        sw_write(2'd0, 32'h3);
        wait_idle();
        check(sb_q.size() == 0, "R6", sb_q.size(), 0);
        check(grants - g0 == 16386, "R6", grants - g0, 16386);
        stall_en = 1'b1;

        // Scenario D: clearing start stops the transfer (R9)
        sw_write(2'd0, 32'h0);
        sw_write(2'd2, 32'h0000_9000);
        load_table(32'h0000_9000, '{32'h0000_A000}, '{400}, 1'b1);
        sw_write(2'd0, 32'h3);
        repeat (20) @(posedge clk);
        sw_write(2'd0, 32'h0);
        g0 = grants;
        repeat (20) @(posedge clk);
        check(grants == g0, "R9", grants, g0);
        sw_read(2'd1, rd); check(rd[0] == 1'b0, "R9", rd, 0);
        check(sb_q.size() > 0, "R9", sb_q.size(), 1);
        sb_q.delete();

        // Scenario E: memory error stops and is write-1-to-clear (R10)
        sw_write(2'd2, 32'h0000_B000);
        load_table(32'h0000_B000, '{32'h0000_C000}, '{16}, 1'b0);
        err_addr = 32'h0000_C008; err_en = 1'b1;
        sw_write(2'd0, 32'h1);
        wait_idle();
        err_en = 1'b0;
        check(sb_q.size() == 1, "R10", sb_q.size(), 1);
        sb_q.delete();
        sw_read(2'd1, rd); check(rd[2:0] == 3'b010, "R10", rd, 2);
        sw_write(2'd1, 32'h0);
        sw_read(2'd1, rd); check(rd[1] == 1'b1, "R10", rd, 2);
        sw_write(2'd1, 32'h2);
        sw_read(2'd1, rd); check(rd[1] == 1'b0, "R10", rd, 0);

        // Scenario F: interrupt status (R11)
        @(posedge clk); #1 dev_irq = 1'b1;
        @(posedge clk); #1 dev_irq = 1'b0;
        sw_read(2'd1, rd); check(rd[2] == 1'b1, "R11", rd, 4);
        sw_write(2'd1, 32'h0);
        sw_read(2'd1, rd); check(rd[2] == 1'b1, "R11", rd, 4);
        sw_write(2'd1, 32'h4);
        sw_read(2'd1, rd); check(rd[2] == 1'b0, "R11", rd, 0);

        finish_run();
    end
endmodule